// File: doc/BRIEF.md
# Reversible Quaternary One-Hot Decoder

This block turns a select word made of quaternary digits into a row of quaternary output lines, of which exactly one carries a non-zero value. Each digit travels as a 2-bit binary code, value v encoded as v. With the default of two select digits there are sixteen output lines.

The block is built as a network of modelled reversible gates rather than as a plain comparator bank. Every output line starts from a constant 0. For that line, single-digit GF(4) shift gates add a fixed constant to each select digit. The constant is chosen so that the line's own select code becomes the all-3 pattern, and no other code does. A controlled shift gate then adds the active value to the constant-0 line, but only when all of its control digits read 3.

GF(4) addition of 2-bit codes is a bitwise XOR, so a shift by z is an XOR with z, and a zero shift is a bare wire. The active value is a parameter and may be 1, 2 or 3. The block is purely combinational and has no clock or reset.

Top module: `qdec_rev`

## Requirements
- R1: For select digits A1 = sel_i[3:2] and A0 = sel_i[1:0], the output with index k = 4*A1 + A0, found at line_o[2k+1:2k], equals ACTIVE_VAL.
- R2: Every output whose index differs from 4*A1 + A0 reads 0.
- R3: Each of the legal ACTIVE_VAL settings 1, 2 and 3 appears unchanged on the selected output.
- R4: For every select code, exactly one output digit is non-zero.
- R5: Select A1A0 = 00 drives only output 0, and select 33 drives only output 15.
- R6: The outputs follow a select change with no clock edge and no state, and no earlier select value leaves a trace on them.
- R7: Digits are 2-bit binary codes in which value v is encoded as v, and GF(4) addition of two digits is their bitwise XOR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | 2*SEL_DIGITS (4) | Select digits; digit j sits at bits [2j+1:2j], with the most significant digit at the top |
| line_o | output | 2*4**SEL_DIGITS (32) | Output digits; output k sits at bits [2k+1:2k] |

## Verification
The bench builds three copies of the decoder with two select digits, one for each ACTIVE_VAL setting of 1, 2 and 3. This means that every alignment shift constant and every possible controlled-shift constant is exercised in the same run. Sweeping all sixteen select codes through each copy covers every output position under every active value. Back-to-back select changes checked without any clock edge show that the network holds no state.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    // One quaternary digit, value v carried as binary v
    typedef logic [1:0] qdigit_t;

    localparam qdigit_t QD_TOP = 2'd3;

    // GF(4) sum of two digits: bitwise XOR of the 2-bit codes
    function automatic qdigit_t gf4_add(input qdigit_t a, input qdigit_t b);
        return a ^ b;
    endfunction

    // Digit number pos of integer k read in base 4
    function automatic qdigit_t digit_of(input int k, input int pos);
        return qdigit_t'((k >> (2 * pos)) & 3);
    endfunction

    // Shift constant that maps digit d onto 3
    function automatic qdigit_t align_shift(input qdigit_t d);
        return gf4_add(QD_TOP, d);
    endfunction

endpackage

// File: rtl/qshift_gate.sv
module qshift_gate
    import qdec_pkg::*;
#(
    parameter qdigit_t SHIFT = 2'd0
) (
    input  qdigit_t x_i,
    output qdigit_t y_o
);

    generate
        if (SHIFT == 2'd0) begin : g_wire
            assign y_o = x_i;
        end else begin : g_shift
            assign y_o = gf4_add(x_i, SHIFT);
        end
    endgenerate

    // R7: applying the same shift again restores the input
    always_comb begin
        shift_inverse_chk: assert (gf4_add(y_o, SHIFT) == x_i)
            else $error("shift gate is not its own inverse");
    end

endmodule

// File: rtl/qctl_shift.sv
module qctl_shift
    import qdec_pkg::*;
#(
    parameter int      NCTL  = 2,
    parameter qdigit_t SHIFT = 2'd1
) (
    input  qdigit_t [NCTL-1:0] ctl_i,
    input  qdigit_t            tgt_i,
    output qdigit_t            tgt_o
);

    logic fire;

    always_comb begin
        fire = 1'b1;
        for (int i = 0; i < NCTL; i++) begin
            fire = fire & (ctl_i[i] == QD_TOP);
        end
    end

    assign tgt_o = fire ? gf4_add(tgt_i, SHIFT) : tgt_i;

    // R6: any control digit other than 3 leaves the target untouched
    always_comb begin
        for (int i = 0; i < NCTL; i++) begin
            if (ctl_i[i] != QD_TOP) begin
                ctl_hold_chk: assert (tgt_o == tgt_i)
                    else $error("target changed with control %0d not at 3", i);
            end
        end
    end

endmodule

// File: rtl/qdec_rev.sv
module qdec_rev
    import qdec_pkg::*;
#(
    parameter int      SEL_DIGITS = 2,
    parameter qdigit_t ACTIVE_VAL = 2'd1,
    localparam int     SEL_W      = 2 * SEL_DIGITS,
    localparam int     NUM_OUT    = 4 ** SEL_DIGITS,
    localparam int     OUT_W      = 2 * NUM_OUT
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [OUT_W-1:0] line_o
);

    // One output line per select code
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
        qdigit_t [SEL_DIGITS-1:0] aligned;

        // Shift every select digit so that code k becomes all 3s
        for (genvar j = 0; j < SEL_DIGITS; j++) begin : g_align
            qshift_gate #(
                .SHIFT(align_shift(digit_of(k, j)))
            ) u_shift (
                .x_i(sel_i[2*j +: 2]),
                .y_o(aligned[j])
            );
        end

        // Fire the active value onto a constant-0 line
        qctl_shift #(
            .NCTL (SEL_DIGITS),
            .SHIFT(ACTIVE_VAL)
        ) u_fire (
            .ctl_i(aligned),
            .tgt_i(2'b00),
            .tgt_o(line_o[2*k +: 2])
        );
    end

    // Checks on the assembled output row
    int nz_cnt;

    always_comb begin
        nz_cnt = 0;
        for (int k = 0; k < NUM_OUT; k++) begin
            if (line_o[2*k +: 2] != 2'b00) begin
                nz_cnt = nz_cnt + 1;
                // R1
                index_match_chk: assert (sel_i == SEL_W'(k))
                    else $error("line %0d active for select %0h", k, sel_i);
                // R3
                active_val_chk: assert (line_o[2*k +: 2] == ACTIVE_VAL)
                    else $error("line %0d carries %0d", k, line_o[2*k +: 2]);
            end
        end
        // R4
        one_hot_chk: assert (nz_cnt == 1)
            else $error("%0d non-zero lines", nz_cnt);
    end

    // R3: only the values 1, 2 and 3 are legal
    always_comb begin
        active_legal_chk: assert (ACTIVE_VAL != 2'd0)
            else $error("active value must be non-zero");
    end

endmodule

// File: tb/qdec_rev_tb_top.sv
module qdec_rev_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;

    // {A1, A0, expected output index}
    localparam logic [7:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 4'd0},  {2'd0, 2'd1, 4'd1},
        {2'd0, 2'd2, 4'd2},  {2'd0, 2'd3, 4'd3},
        {2'd1, 2'd0, 4'd4},  {2'd1, 2'd1, 4'd5},
        {2'd1, 2'd2, 4'd6},  {2'd1, 2'd3, 4'd7},
        {2'd2, 2'd0, 4'd8},  {2'd2, 2'd1, 4'd9},
        {2'd2, 2'd2, 4'd10}, {2'd2, 2'd3, 4'd11},
        {2'd3, 2'd0, 4'd12}, {2'd3, 2'd1, 4'd13},
        {2'd3, 2'd2, 4'd14}, {2'd3, 2'd3, 4'd15}
    };

    logic        clk = 1'b0;
    logic [3:0]  sel = 4'd0;
    logic [31:0] lines_w [3];
    int          total = 0;
    int          bad   = 0;
    logic        done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // One copy per active value: index a carries value a+1
    for (genvar a = 0; a < 3; a++) begin : g_act
        qdec_rev #(
            .SEL_DIGITS(2),
            .ACTIVE_VAL(2'(a + 1))
        ) dut_i (
            .sel_i (sel),
            .line_o(lines_w[a])
        );
    end

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Full row check for one copy against an expected index
    task automatic check_row(input int a, input int idx, input string tag);
        int nz;
        nz = 0;
        for (int k = 0; k < 16; k++) begin
            if (lines_w[a][2*k +: 2] != 2'b00) nz++;
            if (k == idx)
                check(a == 0 ? "R1" : "R3", lines_w[a][2*k +: 2], 2'(a + 1),
                      $sformatf("%s copy=%0d line=%0d selected", tag, a, k));
            else
                check("R2", lines_w[a][2*k +: 2], 2'd0,
                      $sformatf("%s copy=%0d line=%0d idle", tag, a, k));
        end
        // R4: exactly one non-zero digit
        check("R4", 2'(nz), 2'd1, $sformatf("%s copy=%0d non-zero count", tag, a));
    endtask

    initial begin
        // Initial state: select 00 from time zero, R5 corner
        @(negedge clk);
        for (int a = 0; a < 3; a++) check_row(a, 0, "R5 start");

        // Table sweep over all codes, R7 encoding A1 in [3:2]
        for (int v = 0; v < NVEC; v++) begin
            @(posedge clk);
            sel = {VEC[v][7:6], VEC[v][5:4]};
            @(negedge clk);
            for (int a = 0; a < 3; a++) check_row(a, int'(VEC[v][3:0]), "R7 sweep");
        end

        // R5: top corner then bottom corner
        @(posedge clk);
        sel = 4'b1111;
        @(negedge clk);
        for (int a = 0; a < 3; a++) check_row(a, 15, "R5 sel33");
        @(posedge clk);
        sel = 4'b0000;
        @(negedge clk);
        for (int a = 0; a < 3; a++) check_row(a, 0, "R5 sel00");

        // R6: several changes between edges, no clock involved
        @(negedge clk);
        sel = 4'b1001;
        #1;
        for (int a = 0; a < 3; a++) check_row(a, 9, "R6 step1");
        sel = 4'b0110;
        #1;
        for (int a = 0; a < 3; a++) check_row(a, 6, "R6 step2");
        sel = 4'b1100;
        #1;
        for (int a = 0; a < 3; a++) check_row(a, 12, "R6 step3");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule